// File: doc/BRIEF.md
# Merge-Alias Control Register with Level Interrupt

This block holds one 64-bit control/status word on a simple single-cycle register bus. Software can write the word directly, or modify it through alias addresses that merge the write data into the stored value. Only the upper 16 bits are kept; every update forces the lower 48 bits to zero. The most significant stored bit drives a level interrupt line toward an interrupt controller.

A parameter selects one of two layouts. In the AND layout the word sits at word offset 0x4020, offset 0x4021 ANDs the write data in, and 0x4022 ORs it in. In the CLEAR layout the word sits at 0x6080, offset 0x6081 zeroes the whole word whatever the data, and 0x6082 ORs the data in. The word offset is the byte address shifted right by three. Each request receives a registered response one cycle later. A request to any other offset pulses an error flag and changes nothing.

The bus tracker is a two-state machine. In ST_IDLE no response is due. In ST_ACK a response is being presented. The transition GO_ACK (ST_IDLE to ST_ACK) and the transition STAY_ACK (ST_ACK to ST_ACK) happen on a valid request. The transition GO_IDLE (ST_ACK to ST_IDLE) and the transition STAY_IDLE happen when no request is present.

Top module: `misc_alias_reg`

## Requirements
- R1: After reset the stored word is zero, `irq_o` is low, `rsp_valid` is low and `unmapped_o` is low.
- R2: A write to the base offset stores the write data with bits 47:0 forced to zero.
- R3: In the AND layout (`CLEAR_ALT`=0), a write to base+1 stores (stored AND data), masked to bits 63:48.
- R4: In the CLEAR layout (`CLEAR_ALT`=1), a write to base+1 sets the stored word to zero and ignores the write data.
- R5: A write to base+2 stores (stored OR data), masked to bits 63:48, in both layouts.
- R6: Bits 47:0 of the stored word, and so of every base read, are always zero.
- R7: `irq_o` equals bit 63 of the stored word. It changes in the cycle after the write that changes that bit, and it can rise and fall.
- R8: Every request gets `rsp_valid` high in the following cycle. A read of the base offset returns the stored word. A read of base+1 or base+2 returns zero, and every write response carries zero data.
- R9: A read or write to an offset other than base, base+1 or base+2 raises `unmapped_o` for exactly the response cycle, returns zero data and leaves the stored word unchanged.
- R10: The word offset is `req_addr >> 3`; address bits 2:0 do not affect decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data (zero for writes and for non-base reads) |
| unmapped_o | output | 1 | One-cycle flag: the previous request hit no mapped offset |
| irq_o | output | 1 | Level interrupt, equal to stored bit 63 |

## Verification
The assertions assume that `rst_n` is low from time zero and that each request is complete in the cycle it is presented, with address, data and write-enable stable around the clock edge. They also assume that the block is never stalled, because a response always follows one cycle later. The bench drives every input at the falling edge, presents at most one request per cycle, and mixes in idle cycles. It picks unmapped offsets from just outside the three mapped words and from far away, and it randomises address bits 2:0, so that decode is always judged on the shifted offset.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ_REG,
        OP_READ_ZERO,
        OP_LOAD,
        OP_ALT,
        OP_OR,
        OP_UNMAPPED
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_ACK
    } bus_state_e;

    localparam int unsigned BASE_WORD_AND = 32'h4020;
    localparam int unsigned BASE_WORD_CLR = 32'h6080;

endpackage

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
    import misc_alias_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BASE_WORD = 32'h4020
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output op_e               op
);
    localparam int unsigned WORD_W = ADDR_W - 3;
    localparam logic [WORD_W-1:0] W_BASE = WORD_W'(BASE_WORD);
    localparam logic [WORD_W-1:0] W_ALT  = WORD_W'(BASE_WORD + 1);
    localparam logic [WORD_W-1:0] W_OR   = WORD_W'(BASE_WORD + 2);

    logic [WORD_W-1:0] word;
    logic              hit_base, hit_alt, hit_or;

    assign word     = req_addr[ADDR_W-1:3];
    assign hit_base = (word == W_BASE);
    assign hit_alt  = (word == W_ALT);
    assign hit_or   = (word == W_OR);

    always_comb begin
        op = OP_IDLE;
        if (req_valid) begin
            if (req_write) begin
                if (hit_base)     op = OP_LOAD;
                else if (hit_alt) op = OP_ALT;
                else if (hit_or)  op = OP_OR;
                else              op = OP_UNMAPPED;
            end else begin
                if (hit_base)               op = OP_READ_REG;
                else if (hit_alt || hit_or) op = OP_READ_ZERO;
                else                        op = OP_UNMAPPED;
            end
        end
    end

    // R10: at most one mapped word is hit for any offset
    always_comb begin
        assert_single_hit_R10: assert ($countones({hit_base, hit_alt, hit_or}) <= 1);
    end

endmodule

// File: rtl/misc_alias_store.sv
module misc_alias_store
    import misc_alias_pkg::*;
#(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned KEEP_W    = 16,
    parameter bit          CLEAR_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q,
    output logic [DATA_W-1:0] value_nxt
);
    localparam int unsigned DROP_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {DROP_W{1'b0}}};

    logic [DATA_W-1:0] alt_res;
    logic [DATA_W-1:0] merged;

    generate
        if (CLEAR_ALT) begin : g_alt_clear
            assign alt_res = '0;
        end else begin : g_alt_and
            assign alt_res = value_q & wdata;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_LOAD: merged = wdata;
            OP_ALT:  merged = alt_res;
            OP_OR:   merged = value_q | wdata;
            default: merged = value_q;
        endcase
        value_nxt = merged & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_nxt;
    end

    // R6: low field never holds a one
    assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        value_q[DROP_W-1:0] == '0);

    // R5: OR never drops a bit that was already set
    assert_or_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OR) |=> ((value_q & $past(value_q)) == $past(value_q)));

    generate
        if (CLEAR_ALT) begin : g_chk_clear
            // R4: clear alias empties the word
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_ALT) |=> (value_q == '0));
        end else begin : g_chk_and
            // R3: AND alias never sets a bit
            assert_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_ALT) |=> ((value_q & ~$past(value_q)) == '0));
        end
    endgenerate

endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
    import misc_alias_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned KEEP_W    = 16,
    parameter bit          CLEAR_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              unmapped_o,
    output logic              irq_o
);
    localparam int unsigned BASE_WORD = CLEAR_ALT ? BASE_WORD_CLR : BASE_WORD_AND;

    op_e               op;
    logic [DATA_W-1:0] value_q, value_nxt;
    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              unmapped_q, irq_q;

    misc_alias_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_WORD (BASE_WORD)
    ) decode_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op)
    );

    misc_alias_store #(
        .DATA_W    (DATA_W),
        .KEEP_W    (KEEP_W),
        .CLEAR_ALT (CLEAR_ALT)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wdata     (req_wdata),
        .value_q   (value_q),
        .value_nxt (value_nxt)
    );

    // next-state logic: GO_ACK / STAY_ACK / GO_IDLE / STAY_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_ACK : ST_IDLE;
            ST_ACK:  state_d = req_valid ? ST_ACK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            unmapped_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            rdata_q    <= (op == OP_READ_REG) ? value_q : '0;
            unmapped_q <= (op == OP_UNMAPPED);
            irq_q      <= value_nxt[DATA_W-1];
        end
    end

    assign rsp_valid  = (state_q == ST_ACK);
    assign rsp_rdata  = rdata_q;
    assign unmapped_o = unmapped_q;
    assign irq_o      = irq_q;

    // R7: interrupt line mirrors stored top bit
    assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == value_q[DATA_W-1]);

    // R7: interrupt moves only after a write request
    assert_irq_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != $past(irq_o)) |-> $past(req_valid && req_write));

    // R8: a response follows a request
    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R8: reads other than the base word return zero
    assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(op != OP_READ_REG)) |-> (rsp_rdata == '0));

    // R9: unmapped flag only accompanies a response and leaves the word alone
    assert_unmapped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_o |-> (rsp_valid && $stable(value_q) && rsp_rdata == '0));

endmodule

// File: tb/misc_alias_reg_tb_top.sv
module misc_alias_reg_tb_top;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 64;
    localparam logic [63:0] KEEP = 64'hFFFF_0000_0000_0000;
    localparam int unsigned BASE_A = 32'h4020;
    localparam int unsigned BASE_B = 32'h6080;

    typedef struct packed {
        logic [63:0] rd_a;
        logic [63:0] rd_b;
        logic        unm;
        logic        irq_a;
        logic        irq_b;
        logic [3:0]  kind;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] wdata = '0;
    logic          rv_a, rv_b, un_a, un_b, irq_a, irq_b;
    logic [DW-1:0] rd_a, rd_b;

    int   n_tests = 0, n_fail = 0;
    bit   done = 0;
    exp_t q[$];
    logic [63:0] m_a = '0, m_b = '0;

    always #10 clk = ~clk;

    misc_alias_reg #(.ADDR_W(AW), .DATA_W(DW), .KEEP_W(16), .CLEAR_ALT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(addr_a), .req_wdata(wdata), .rsp_valid(rv_a), .rsp_rdata(rd_a),
        .unmapped_o(un_a), .irq_o(irq_a));

    misc_alias_reg #(.ADDR_W(AW), .DATA_W(DW), .KEEP_W(16), .CLEAR_ALT(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(addr_b), .req_wdata(wdata), .rsp_valid(rv_b), .rsp_rdata(rd_b),
        .unmapped_o(un_b), .irq_o(irq_b));

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kinds: 0 load, 1 alt, 2 or, 3 read base, 4 read alias, 5 unmapped wr, 6 unmapped rd, 7 idle
    task automatic drive(input int kind, input logic [63:0] d);
        exp_t e;
        int   off;
        logic [2:0] lo;
        @(negedge clk);
        lo  = 3'($urandom);
        off = 0;
        case (kind)
            1: off = 1;
            2: off = 2;
            4: off = 1 + int'($urandom % 2);
            5, 6: off = ($urandom % 2) ? 3 : 32'h100;
            default: off = 0;
        endcase
        req_valid = (kind != 7);
        req_write = (kind <= 2) || (kind == 5);
        wdata     = d;
        addr_a    = ((BASE_A + off) << 3) | 32'(lo);
        addr_b    = ((BASE_B + off) << 3) | 32'(lo);
        if (kind == 7) return;
        e       = '0;
        e.kind  = 4'(kind);
        e.rd_a  = (kind == 3) ? m_a : '0;
        e.rd_b  = (kind == 3) ? m_b : '0;
        e.unm   = (kind == 5) || (kind == 6);
        case (kind)
            0: begin m_a = d & KEEP; m_b = d & KEEP; end
            1: begin m_a = m_a & d & KEEP; m_b = '0; end
            2: begin m_a = (m_a | d) & KEEP; m_b = (m_b | d) & KEEP; end
            default: ;
        endcase
        e.irq_a = m_a[63];
        e.irq_b = m_b[63];
        q.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (rv_a || rv_b) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", 64'(rv_a), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rv_a && rv_b, "R8 rsp_valid both", {62'd0, rv_a, rv_b}, 64'd3);
                    check(rd_a === e.rd_a, (e.kind == 3) ? "R8 R6 base read A" : "R8 R9 zero data A", rd_a, e.rd_a);
                    check(rd_b === e.rd_b, (e.kind == 3) ? "R8 R6 base read B (R4 R5 state)" : "R8 R9 zero data B", rd_b, e.rd_b);
                    check(un_a === e.unm && un_b === e.unm, "R9 unmapped flag", {62'd0, un_a, un_b}, {62'd0, e.unm, e.unm});
                    check(irq_a === e.irq_a, "R7 irq A", 64'(irq_a), 64'(e.irq_a));
                    check(irq_b === e.irq_b, "R7 irq B", 64'(irq_b), 64'(e.irq_b));
                end
            end else begin
                check(!un_a && !un_b, "R9 flag outside response", {62'd0, un_a, un_b}, 64'd0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(!rv_a && !rv_b, "R1 rsp_valid low", {62'd0, rv_a, rv_b}, 64'd0);
        check(!irq_a && !irq_b, "R1 irq low", {62'd0, irq_a, irq_b}, 64'd0);
        check(!un_a && !un_b, "R1 unmapped low", {62'd0, un_a, un_b}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3, '0);                              // R1 word reads zero
        drive(0, 64'hFFFF_FFFF_FFFF_FFFF);         // R2 R6 R7 rise
        drive(3, '0);
        drive(1, 64'h7FFF_FFFF_FFFF_FFFF);         // R3 AND drops bit63 / R4 clear
        drive(3, '0);
        drive(2, 64'h8001_0000_0000_1234);         // R5 OR, R7 rise again
        drive(3, '0);
        drive(4, '0);                              // R8 alias read zero
        drive(5, 64'h0);                           // R9 unmapped write
        drive(3, '0);
        drive(6, '0);                              // R9 unmapped read
        drive(7, '0);
        drive(0, 64'h0000_FFFF_FFFF_FFFF);         // R6 low bits dropped, R7 fall
        drive(3, '0);
        drive(0, 64'hA5A5_0000_0000_0000);
        drive(1, 64'hFFFF_FFFF_FFFF_FFFF);         // R4 clear ignores data
        drive(3, '0);
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [63:0] d;
            k = int'($urandom % 8);
            d = {$urandom, $urandom};
            drive(k, d);
        end
        drive(3, '0);
        drive(7, '0);
        repeat (3) @(posedge clk);
        #2;
        check(q.size() == 0, "R8 all responses seen", 64'(q.size()), 64'd0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule